// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous host and an 8192-word by 8-bit asynchronous static RAM. The host hands over one word at a time on a valid/ready request port: a 13-bit address, a direction flag and, for stores, an 8-bit value. The controller plays out the RAM's pin sequence for that access: the address, a chip-enable pair of opposite polarity, an active-low output enable, an active-low write enable, and the drive-enable and data lines of the shared data bus. A load ends with a one-cycle strobe that carries the fetched byte back to the host.

Every asynchronous timing minimum is given in nanoseconds, together with the clock period. At elaboration each one becomes a whole number of cycles, rounded up. The state machine runs through named states:
- `ST_IDLE`: ready, all pins at rest.
- `ST_WR_SETUP`: address and chip enables applied.
- `ST_WR_PULSE`: write enable low and data driven.
- `ST_WR_RELEASE`: write enable high, data still driven.
- `ST_RD_ACCESS`: chip enables and output enable asserted.
- `ST_GAP`: bus turnaround, everything at rest.

Its transitions are:
- accept-write: `ST_IDLE` to `ST_WR_SETUP`.
- accept-read: `ST_IDLE` to `ST_RD_ACCESS`.
- setup-done: `ST_WR_SETUP` to `ST_WR_PULSE`.
- pulse-done: `ST_WR_PULSE` to `ST_WR_RELEASE`.
- release-done: `ST_WR_RELEASE` to `ST_GAP`.
- access-done: `ST_RD_ACCESS` to `ST_GAP`.
- gap-done: `ST_GAP` to `ST_IDLE`.

All pins come straight from flops, so they are free of glitches. Because the gap keeps the host waiting, the RAM and the controller never drive the bus at the same time.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and whenever `req_ready` is high, the pins rest at `sram_ce1_n`=1, `sram_ce2`=0, `sram_oe_n`=1, `sram_we_n`=1 and `sram_dq_oe`=0. `rd_valid` is 0 while in reset.
- R2: `sram_ce1_n` is always the inverse of `sram_ce2`, so the RAM is either fully selected or fully deselected.
- R3: Each store holds `sram_we_n` low for exactly N_WP cycles. N_WP is the largest of: ceil(write-pulse minimum / clock), ceil(data-setup minimum / clock), and ceil(write-cycle minimum / clock) − N_SETUP − 1. With the defaults this gives 3.
- R4: `sram_dq_oe` is high in every cycle that `sram_we_n` is low, and also in the one cycle after `sram_we_n` rises. It falls in the cycle after that. `sram_dq_out` stays constant while `sram_we_n` is low, so the RAM stores the host's byte.
- R5: `sram_addr` changes only when `sram_we_n` is high both in the cycle before the change and in the cycle of the change.
- R6: Each load holds `sram_oe_n` low for exactly N_RD cycles. N_RD is the largest of the rounded-up read-cycle, address-access, enable-access and output-enable-access minimums. With the defaults this gives 4. The bus value is sampled on the last of those cycles. `rd_valid` is high for one cycle, N_RD cycles after the accepting edge, with `rd_data` set to the stored byte.
- R7: `sram_dq_oe` is never high while `sram_oe_n` is low. Data drive never starts until `sram_oe_n` has been high for at least N_GAP cycles, where N_GAP = ceil(output-float maximum / clock). With the defaults this gives 2.
- R8: `req_ready` goes low on the cycle after a request is accepted and stays low until the end of the turnaround gap. For a load it stays low for N_RD + N_GAP cycles (6 with defaults). For a store it stays low for 1 + N_WP + 1 + N_GAP cycles (7 with defaults).
- R9: `sram_oe_n` and `sram_we_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W (13) | Word address |
| req_wdata | input | DATA_W (8) | Byte to store |
| rd_valid | output | 1 | One-cycle strobe with load data |
| rd_data | output | DATA_W (8) | Loaded byte |
| sram_addr | output | ADDR_W (13) | RAM address pins |
| sram_ce1_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_dq_out | output | DATA_W (8) | Data toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_dq_in | input | DATA_W (8) | Data from the RAM |

## Verification
Each request is counted from the rising edge that accepts it. With the default timing, `rd_valid` shows up 4 cycles after that edge. `req_ready` comes back 6 cycles after the edge for a load and 7 cycles after it for a store. The write-enable and output-enable pulses last 3 and 4 cycles respectively.

The bench drives its inputs on falling edges and samples on falling edges. It counts falling edges from acceptance until `req_ready` is high again, so every latency and width is measured rather than sampled at a guessed instant. The stored and loaded bytes are compared against a shadow memory kept by the bench. A RAM model tracks pin-level rules on every cycle in its own violation counters, which are checked at the end.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WR_SETUP   = 3'd1,
        ST_WR_PULSE   = 3'd2,
        ST_WR_RELEASE = 3'd3,
        ST_RD_ACCESS  = 3'd4,
        ST_GAP        = 3'd5
    } ctrl_state_t;

    // Whole cycles covering t_ns, never fewer than one.
    function automatic int cycles_for(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_pin_driver.sv
module sram_pin_driver
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_state_t       state_nxt,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe
);
    logic sel_d, oe_d, we_d, drv_d;

    // Pin levels wanted in the state that the next edge enters.
    always_comb begin
        sel_d = 1'b0;
        oe_d  = 1'b0;
        we_d  = 1'b0;
        drv_d = 1'b0;
        unique case (state_nxt)
            ST_IDLE:       ;
            ST_GAP:        ;
            ST_WR_SETUP:   sel_d = 1'b1;
            ST_WR_PULSE: begin
                sel_d = 1'b1;
                we_d  = 1'b1;
                drv_d = 1'b1;
            end
            ST_WR_RELEASE: begin
                sel_d = 1'b1;
                drv_d = 1'b1;
            end
            ST_RD_ACCESS: begin
                sel_d = 1'b1;
                oe_d  = 1'b1;
            end
            default:       ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sram_ce1_n <= 1'b1;
            sram_ce2   <= 1'b0;
            sram_oe_n  <= 1'b1;
            sram_we_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
        end else begin
            sram_ce1_n <= ~sel_d;
            sram_ce2   <= sel_d;
            sram_oe_n  <= ~oe_d;
            sram_we_n  <= ~we_d;
            sram_dq_oe <= drv_d;
        end
    end

    // Address and data only move on acceptance, which happens in idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sram_addr   <= '0;
            sram_dq_out <= '0;
        end else if (accept) begin
            sram_addr   <= req_addr;
            sram_dq_out <= req_wdata;
        end
    end

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture)
                rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_RC_NS   = 35,
    parameter int T_WC_NS   = 35,
    parameter int T_AA_NS   = 35,
    parameter int T_ACE_NS  = 35,
    parameter int T_OE_NS   = 15,
    parameter int T_WP_NS   = 25,
    parameter int T_DS_NS   = 15,
    parameter int T_AS_NS   = 0,
    parameter int T_HZ_NS   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int N_SETUP = cycles_for(T_AS_NS, CLK_NS);
    localparam int N_WP    = max_of(max_of(cycles_for(T_WP_NS, CLK_NS),
                                           cycles_for(T_DS_NS, CLK_NS)),
                                    cycles_for(T_WC_NS, CLK_NS) - N_SETUP - 1);
    localparam int N_RD    = max_of(max_of(cycles_for(T_AA_NS, CLK_NS),
                                           cycles_for(T_ACE_NS, CLK_NS)),
                                    max_of(cycles_for(T_OE_NS, CLK_NS),
                                           cycles_for(T_RC_NS, CLK_NS)));
    localparam int N_GAP   = cycles_for(T_HZ_NS, CLK_NS);
    localparam int N_MAX   = max_of(max_of(N_SETUP, N_WP), max_of(N_RD, N_GAP));
    localparam int CNT_W   = $clog2(N_MAX + 1);

    ctrl_state_t      state_q, state_nxt;
    logic             accept;
    logic             phase_done;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_nxt;
    end

    // Transitions.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:
                if (accept)
                    state_nxt = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_WR_SETUP:
                if (phase_done) state_nxt = ST_WR_PULSE;
            ST_WR_PULSE:
                if (phase_done) state_nxt = ST_WR_RELEASE;
            ST_WR_RELEASE:
                if (phase_done) state_nxt = ST_GAP;
            ST_RD_ACCESS:
                if (phase_done) state_nxt = ST_GAP;
            ST_GAP:
                if (phase_done) state_nxt = ST_IDLE;
            default:
                state_nxt = ST_IDLE;
        endcase
    end

    // Phase length for the state being entered.
    always_comb begin
        timer_load = (state_nxt != state_q);
        unique case (state_nxt)
            ST_WR_SETUP:   timer_val = CNT_W'(N_SETUP - 1);
            ST_WR_PULSE:   timer_val = CNT_W'(N_WP - 1);
            ST_WR_RELEASE: timer_val = '0;
            ST_RD_ACCESS:  timer_val = CNT_W'(N_RD - 1);
            ST_GAP:        timer_val = CNT_W'(N_GAP - 1);
            default:       timer_val = '0;
        endcase
    end

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .done     (phase_done)
    );

    sram_pin_driver #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_nxt   (state_nxt),
        .accept      (accept),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .sram_addr   (sram_addr),
        .sram_ce1_n  (sram_ce1_n),
        .sram_ce2    (sram_ce2),
        .sram_oe_n   (sram_oe_n),
        .sram_we_n   (sram_we_n),
        .sram_dq_out (sram_dq_out),
        .sram_dq_oe  (sram_dq_oe)
    );

    sram_read_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  ((state_q == ST_RD_ACCESS) && phase_done),
        .dq_in    (sram_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int ADDR_W     = 13,
    parameter int WP_CYCLES  = 3,
    parameter int RD_CYCLES  = 4,
    parameter int GAP_CYCLES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce1_n,
    input logic              sram_ce2,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              sram_dq_oe
);
    int we_low_cnt;
    int oe_low_cnt;
    int oe_high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt  <= 0;
            oe_low_cnt  <= 0;
            oe_high_cnt <= GAP_CYCLES;
        end else begin
            we_low_cnt  <= sram_we_n ? 0 : we_low_cnt + 1;
            oe_low_cnt  <= sram_oe_n ? 0 : oe_low_cnt + 1;
            if (!sram_oe_n)
                oe_high_cnt <= 0;
            else if (oe_high_cnt < GAP_CYCLES)
                oe_high_cnt <= oe_high_cnt + 1;
        end
    end

    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce1_n && !sram_ce2 && sram_oe_n && sram_we_n && !sram_dq_oe));

    assert_enable_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sram_ce1_n == !sram_ce2);

    assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt == WP_CYCLES));

    assert_drive_during_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_dq_oe);

    assert_drive_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_dq_oe ##1 !sram_dq_oe);

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sram_addr) |-> (sram_we_n && $past(sram_we_n)));

    assert_oe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (oe_low_cnt == RD_CYCLES));

    assert_rd_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!sram_oe_n) && sram_oe_n) ##1 !rd_valid);

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (oe_high_cnt >= GAP_CYCLES));

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n));

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
    .ADDR_W     (ADDR_W),
    .WP_CYCLES  (N_WP),
    .RD_CYCLES  (N_RD),
    .GAP_CYCLES (N_GAP)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .sram_addr  (sram_addr),
    .sram_ce1_n (sram_ce1_n),
    .sram_ce2   (sram_ce2),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 13;
    localparam int DW = 8;

    // Expected phase lengths from the requirements at default timing.
    function automatic int ceil_div(input int a, input int b);
        int c;
        c = (a + b - 1) / b;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int EXP_WP  = 3;   // max(ceil(25/10), ceil(15/10), ceil(35/10)-1-1)
    localparam int EXP_RD  = 4;   // ceil(35/10)
    localparam int EXP_GAP = 2;   // ceil(15/10)

    function automatic int exp_busy(input bit wr);
        return wr ? (1 + EXP_WP + 1 + EXP_GAP) : (EXP_RD + EXP_GAP);
    endfunction

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] sram_addr;
    logic          sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_out;
    logic [DW-1:0] sram_dq_in = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int viol_r2 = 0, viol_r4 = 0, viol_r5 = 0, viol_r7 = 0, viol_r9 = 0;

    logic [DW-1:0] ram_mem [int];
    logic [DW-1:0] shadow  [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_async_ctrl u_sram_async_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .sram_addr   (sram_addr),
        .sram_ce1_n  (sram_ce1_n),
        .sram_ce2    (sram_ce2),
        .sram_oe_n   (sram_oe_n),
        .sram_we_n   (sram_we_n),
        .sram_dq_out (sram_dq_out),
        .sram_dq_oe  (sram_dq_oe),
        .sram_dq_in  (sram_dq_in)
    );

    function automatic logic [DW-1:0] ram_peek(input int a);
        return ram_mem.exists(a) ? ram_mem[a] : '0;
    endfunction

    function automatic logic [DW-1:0] shadow_peek(input int a);
        return shadow.exists(a) ? shadow[a] : '0;
    endfunction

    // Behavioural RAM and pin-rule monitor, sampled on falling edges.
    logic          prev_we_n = 1'b1;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_dq   = '0;
    int            oe_high_run = 100;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sram_ce1_n != !sram_ce2) viol_r2++;
            if (!sram_we_n && !prev_we_n && sram_dq_out != prev_dq) viol_r4++;
            if (!sram_we_n && !sram_dq_oe) viol_r4++;
            if (sram_addr != prev_addr && (!sram_we_n || !prev_we_n)) viol_r5++;
            if (sram_dq_oe && !sram_oe_n) viol_r7++;
            if (sram_dq_oe && oe_high_run < EXP_GAP) viol_r7++;
            if (!sram_oe_n && !sram_we_n) viol_r9++;
            if (!prev_we_n && sram_we_n && !sram_ce1_n && sram_ce2 && sram_dq_oe)
                ram_mem[int'(sram_addr)] = sram_dq_out;
            if (!sram_ce1_n && sram_ce2 && !sram_oe_n && sram_we_n)
                sram_dq_in <= ram_peek(int'(sram_addr));
            else
                sram_dq_in <= '0;
            if (!sram_oe_n) oe_high_run = 0;
            else if (oe_high_run < 100) oe_high_run++;
        end
        prev_we_n = sram_we_n;
        prev_addr = sram_addr;
        prev_dq   = sram_dq_out;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int cyc, lat, we_lo, oe_lo;
        logic [DW-1:0] got;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        cyc = 0; lat = -1; we_lo = 0; oe_lo = 0; got = '0;
        forever begin
            @(negedge clk);
            if (cyc == 0) req_valid = 1'b0;
            cyc++;
            if (!sram_we_n) we_lo++;
            if (!sram_oe_n) oe_lo++;
            if (rd_valid) begin
                lat = cyc - 1;
                got = rd_data;
            end
            if (req_ready) break;
        end
        check((cyc - 1) == exp_busy(wr), "R8 busy cycles", cyc - 1, exp_busy(wr));
        if (wr) begin
            shadow[int'(a)] = d;
            check(we_lo == EXP_WP, "R3 write pulse", we_lo, EXP_WP);
            check(oe_lo == 0, "R9 oe during store", oe_lo, 0);
            check(ram_peek(int'(a)) == d, "R4 stored byte", ram_peek(int'(a)), d);
        end else begin
            check(oe_lo == EXP_RD, "R6 oe width", oe_lo, EXP_RD);
            check(lat == EXP_RD, "R6 strobe latency", lat, EXP_RD);
            check(got == shadow_peek(int'(a)), "R6 load data", got, shadow_peek(int'(a)));
            check(we_lo == 0, "R9 we during load", we_lo, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(sram_ce1_n && !sram_ce2 && sram_oe_n && sram_we_n && !sram_dq_oe,
              "R1 pins in reset", {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b10110);
        check(!rd_valid, "R1 strobe in reset", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R8 ready after reset", req_ready, 1);
        check(sram_ce1_n && !sram_ce2 && sram_oe_n && sram_we_n && !sram_dq_oe,
              "R1 idle pins", {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b10110);

        // Directed corners: lowest and highest address, unwritten word, overwrite.
        run_op(1'b1, 13'd0,    8'hA5);
        run_op(1'b1, 13'd8191, 8'h3C);
        run_op(1'b0, 13'd0,    8'h00);
        run_op(1'b0, 13'd8191, 8'h00);
        run_op(1'b0, 13'd100,  8'h00);
        run_op(1'b1, 13'd7,    8'hFF);
        run_op(1'b1, 13'd7,    8'h00);
        run_op(1'b0, 13'd7,    8'h00);
        run_op(1'b0, 13'd7,    8'h00);

        // Random mix over a small address window with occasional extremes.
        for (int i = 0; i < 150; i++) begin
            logic [AW-1:0] a;
            a = ($urandom % 8 == 0) ? AW'($urandom) : AW'($urandom % 32);
            run_op(1'($urandom), a, DW'($urandom));
            check(sram_ce1_n && !sram_ce2 && sram_oe_n && sram_we_n && !sram_dq_oe,
                  "R1 idle between ops",
                  {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe}, 5'b10110);
        end

        check(viol_r2 == 0, "R2 enable pair", viol_r2, 0);
        check(viol_r4 == 0, "R4 data drive", viol_r4, 0);
        check(viol_r5 == 0, "R5 address hold", viol_r5, 0);
        check(viol_r7 == 0, "R7 bus contention", viol_r7, 0);
        check(viol_r9 == 0, "R9 strobe overlap", viol_r9, 0);
        check(ceil_div(35, CLK_PERIOD) == EXP_RD, "R6 derived length", ceil_div(35, CLK_PERIOD), EXP_RD);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule